// File: doc/BRIEF.md
# DDR DLL and Extended Mode Register Sequencer

This block belongs to a DDR SDRAM controller. On a configure request it writes the extended mode register of the memory with a new DLL setting and a new output drive strength. When that write switches the DLL on, it then writes the base mode register with the DLL-reset bit set. It also keeps a read-permit flag low until the DLL has had a fixed number of clocks to lock.

A request is held until the controller reports every bank idle and no burst in flight. After each mode register load the block leaves a parameterised gap of NOP cycles before the next command, and it marks the end of the sequence with a single-cycle done pulse. A self-refresh-exit pulse also turns the DLL on, so it restarts the lock wait.

The command pins, the bank select and the row address all come from registers. The row address width is a parameter that is set to 12 or 13.

Top module: `dmr_seq`

## Requirements
- R1: While reset is held low and in the first cycle after it, the bus carries a NOP. A NOP is chip select low with the row strobe, column strobe and write enable all high, `ba` = 0 and `addr` = 0. In the same cycles `done` is 0 and `rd_ok` is 1.
- R2: `cfg_req` is sampled only when no sequence is running. The settings are captured at that edge. A request or a settings change made while a sequence runs does not produce any further mode register load.
- R3: After a request, no mode register load is issued while `banks_idle` is low. The extended load appears in the cycle after the first edge that samples `banks_idle` high.
- R4: The extended load drives all four command pins low with `ba` = 2'b01. `addr[0]` is the inverse of `cfg_dll_on`, so 0 means the DLL is enabled. `addr[1]` equals `cfg_drive_half`. Every address bit from bit 2 up to bit ROW_W-1 is 0.
- R5: When the captured setting enables the DLL, a base mode register load follows, with `ba` = 2'b00 and `addr` = BASE_MODE with bit DLL_RST_BIT set. When the DLL is disabled, no base load is issued. `ba` never takes the values 2'b10 or 2'b11.
- R6: Every mode register load is followed by exactly LMR_GAP NOP cycles. Only then does the next load or the done pulse appear.
- R7: Every cycle that is not a mode register load is a NOP with `ba` and `addr` zero.
- R8: `rd_ok` is 0 from the edge after `cfg_req` is accepted until the done cycle. After an extended load that enables the DLL, `rd_ok` stays 0 for LOCK_CYC cycles counted from that load cycle, and it returns to 1 in cycle LOCK_CYC after it.
- R9: When a `sr_exit` pulse is sampled, `rd_ok` is 0 from the next cycle for LOCK_CYC cycles. This holds in any state.
- R10: `done` is high for exactly one cycle, in the cycle after the last gap NOP of a sequence. In that same cycle a new request can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Start a programming sequence |
| cfg_dll_on | input | 1 | 1 = enable the DLL |
| cfg_drive_half | input | 1 | Drive strength selection, copied to address bit 1 |
| banks_idle | input | 1 | All banks idle and no burst active |
| sr_exit | input | 1 | Self-refresh exit pulse; restarts the lock wait |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ROW_W | Row address bus |
| rd_ok | output | 1 | READ commands permitted |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bound checker covers the properties that hold on every cycle. These are the shape of each load (bank select, reserved bits, base word), NOP cleanliness, one load per gap, and the stall on idle. It also counts the lock window independently of the design and checks that `rd_ok` never rises before that count ends, and that a self-refresh exit drops `rd_ok`. Only the bench scenarios can show the rest. That means the exact cycle on which `rd_ok` comes back, that a request made during a busy sequence is really dropped rather than queued, and that a disabled-DLL sequence omits the base load. It also covers a self-refresh exit arriving while a holdoff is already running.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_GAP_EXT,
        ST_GAP_BASE
    } seq_state_e;

    typedef enum logic {
        CMD_NOP,
        CMD_LMR
    } cmd_kind_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam logic [1:0] BA_BASE = 2'b00;
    localparam logic [1:0] BA_EXT  = 2'b01;
endpackage

// File: rtl/dmr_cmd_enc.sv
module dmr_cmd_enc
    import dmr_pkg::*;
(
    input  cmd_kind_e kind,
    output cmd_pins_t pins
);
    always_comb begin
        pins.cs_n = 1'b0;
        case (kind)
            CMD_LMR: begin
                pins.ras_n = 1'b0;
                pins.cas_n = 1'b0;
                pins.we_n  = 1'b0;
            end
            default: begin
                pins.ras_n = 1'b1;
                pins.cas_n = 1'b1;
                pins.we_n  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dmr_holdoff.sv
module dmr_holdoff #(
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic busy
);
    localparam int CNT_W = $clog2(LOCK_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = CNT_W'(LOCK_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/dmr_seq.sv
module dmr_seq
    import dmr_pkg::*;
#(
    parameter int ROW_W       = 13,
    parameter int LMR_GAP     = 2,
    parameter int LOCK_CYC    = 200,
    parameter int BASE_MODE   = 'h022,
    parameter int DLL_RST_BIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_req,
    input  logic             cfg_dll_on,
    input  logic             cfg_drive_half,
    input  logic             banks_idle,
    input  logic             sr_exit,
    output logic             cmd_cs_n,
    output logic             cmd_ras_n,
    output logic             cmd_cas_n,
    output logic             cmd_we_n,
    output logic [1:0]       ba,
    output logic [ROW_W-1:0] addr,
    output logic             rd_ok,
    output logic             done
);
    localparam int               GAP_W     = $clog2(LMR_GAP + 2);
    localparam logic [GAP_W-1:0] GAP_INIT  = GAP_W'(LMR_GAP);
    localparam logic [ROW_W-1:0] BASE_WORD = ROW_W'(BASE_MODE) | (ROW_W'(1) << DLL_RST_BIT);

    typedef struct packed {
        seq_state_e       st;
        logic [GAP_W-1:0] gap;
        logic             dll_on;
        logic             drv;
        cmd_kind_e        cmd;
        logic [1:0]       ba;
        logic [ROW_W-1:0] addr;
        logic             done;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic             lock_load;
    logic             lock_busy;
    logic [ROW_W-1:0] ext_word;
    cmd_pins_t        pins;

    always_comb begin
        ext_word    = '0;
        ext_word[0] = ~seq_q.dll_on;
        ext_word[1] = seq_q.drv;

        seq_d      = seq_q;
        seq_d.cmd  = CMD_NOP;
        seq_d.ba   = '0;
        seq_d.addr = '0;
        seq_d.done = 1'b0;
        lock_load  = sr_exit;

        case (seq_q.st)
            ST_IDLE: begin
                if (cfg_req) begin
                    seq_d.st     = ST_WAIT;
                    seq_d.dll_on = cfg_dll_on;
                    seq_d.drv    = cfg_drive_half;
                end
            end
            ST_WAIT: begin
                if (banks_idle) begin
                    seq_d.cmd  = CMD_LMR;
                    seq_d.ba   = BA_EXT;
                    seq_d.addr = ext_word;
                    seq_d.gap  = GAP_INIT;
                    seq_d.st   = ST_GAP_EXT;
                    if (seq_q.dll_on) begin
                        lock_load = 1'b1;
                    end
                end
            end
            ST_GAP_EXT: begin
                if (seq_q.gap != '0) begin
                    seq_d.gap = seq_q.gap - GAP_W'(1);
                end else if (seq_q.dll_on) begin
                    seq_d.cmd  = CMD_LMR;
                    seq_d.ba   = BA_BASE;
                    seq_d.addr = BASE_WORD;
                    seq_d.gap  = GAP_INIT;
                    seq_d.st   = ST_GAP_BASE;
                end else begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end
            end
            ST_GAP_BASE: begin
                if (seq_q.gap != '0) begin
                    seq_d.gap = seq_q.gap - GAP_W'(1);
                end else begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, gap: '0, dll_on: 1'b0, drv: 1'b0,
                       cmd: CMD_NOP, ba: '0, addr: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    dmr_holdoff #(.LOCK_CYC(LOCK_CYC)) u_holdoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (lock_load),
        .busy    (lock_busy)
    );

    dmr_cmd_enc u_enc (
        .kind (seq_q.cmd),
        .pins (pins)
    );

    assign cmd_cs_n  = pins.cs_n;
    assign cmd_ras_n = pins.ras_n;
    assign cmd_cas_n = pins.cas_n;
    assign cmd_we_n  = pins.we_n;
    assign ba        = seq_q.ba;
    assign addr      = seq_q.addr;
    assign done      = seq_q.done;
    assign rd_ok     = (seq_q.st == ST_IDLE) && !lock_busy;
endmodule

// File: rtl/dmr_seq_chk.sv
module dmr_seq_chk #(
    parameter int ROW_W       = 13,
    parameter int LMR_GAP     = 2,
    parameter int LOCK_CYC    = 200,
    parameter int BASE_MODE   = 'h022,
    parameter int DLL_RST_BIT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             banks_idle,
    input logic             sr_exit,
    input logic             cmd_cs_n,
    input logic             cmd_ras_n,
    input logic             cmd_cas_n,
    input logic             cmd_we_n,
    input logic [1:0]       ba,
    input logic [ROW_W-1:0] addr,
    input logic             rd_ok,
    input logic             done
);
    localparam int               CNT_W   = $clog2(LOCK_CYC + 1);
    localparam logic [ROW_W-1:0] EXP_BASE = ROW_W'(BASE_MODE) | (ROW_W'(1) << DLL_RST_BIT);

    logic             lmr;
    logic [CNT_W-1:0] win_q;

    assign lmr = !cmd_cs_n && !cmd_ras_n && !cmd_cas_n && !cmd_we_n;

    // Independent lock-window counter, built from the port view only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (sr_exit) begin
            win_q <= CNT_W'(LOCK_CYC);
        end else if (lmr && ba == 2'b01 && !addr[0]) begin
            win_q <= CNT_W'(LOCK_CYC - 1);
        end else if (win_q != '0) begin
            win_q <= win_q - CNT_W'(1);
        end
    end

    p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lmr && ba == 2'b01) |-> $past(banks_idle));

    p_ext_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lmr && ba == 2'b01) |-> (addr[ROW_W-1:2] == '0));

    p_base_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lmr && ba == 2'b00) |-> (addr == EXP_BASE));

    p_bank_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lmr |-> (ba[1] == 1'b0));

    generate
        if (LMR_GAP > 0) begin : g_gap
            p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
                lmr |=> !lmr);
        end
    endgenerate

    p_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !lmr |-> (!cmd_cs_n && cmd_ras_n && cmd_cas_n && cmd_we_n && ba == 2'b00 && addr == '0));

    p_lock_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> (win_q == '0));

    p_sr_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_exit |=> !rd_ok);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind dmr_seq dmr_seq_chk #(
    .ROW_W       (ROW_W),
    .LMR_GAP     (LMR_GAP),
    .LOCK_CYC    (LOCK_CYC),
    .BASE_MODE   (BASE_MODE),
    .DLL_RST_BIT (DLL_RST_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .banks_idle (banks_idle),
    .sr_exit    (sr_exit),
    .cmd_cs_n   (cmd_cs_n),
    .cmd_ras_n  (cmd_ras_n),
    .cmd_cas_n  (cmd_cas_n),
    .cmd_we_n   (cmd_we_n),
    .ba         (ba),
    .addr       (addr),
    .rd_ok      (rd_ok),
    .done       (done)
);

// File: tb/dmr_seq_test.sv
module dmr_seq_test;
    localparam int          GAP       = 2;
    localparam int          LOCK      = 200;
    localparam logic [12:0] BASE_WORD = 13'h0122;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_req = 1'b0;
    logic        cfg_dll_on = 1'b0;
    logic        cfg_drive_half = 1'b0;
    logic        banks_idle = 1'b0;
    logic        sr_exit = 1'b0;
    logic        cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic        rd_ok, done;

    dmr_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_dll_on(cfg_dll_on),
        .cfg_drive_half(cfg_drive_half), .banks_idle(banks_idle), .sr_exit(sr_exit),
        .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
        .cmd_we_n(cmd_we_n), .ba(ba), .addr(addr), .rd_ok(rd_ok), .done(done)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic        lmr;
        logic [1:0]  ba;
        logic [12:0] addr;
        logic        done;
    } slot_t;

    slot_t q[$];
    slot_t exp_s = '0;
    int    hold = 0;
    bit    busy = 0, waiting = 0, m_dll = 0, m_drv = 0, last_sr = 0;
    int    checks = 0, errors = 0, lmr_seen = 0;
    bit    finished = 0;

    function automatic slot_t mk(bit l, logic [1:0] b, logic [12:0] a, bit d);
        slot_t s;
        s.lmr = l; s.ba = b; s.addr = a; s.done = d;
        return s;
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // Behavioural reference: a schedule of future bus slots.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            exp_s = '0; hold = 0; busy = 0; waiting = 0; last_sr = 0;
        end else begin
            if (hold > 0) hold--;
            if (sr_exit) begin hold = LOCK; last_sr = 1; end
            exp_s = '0;
            if (!busy) begin
                if (cfg_req) begin
                    busy = 1; waiting = 1; m_dll = cfg_dll_on; m_drv = cfg_drive_half;
                end
            end else if (waiting) begin
                if (banks_idle) begin
                    waiting = 0;
                    q.push_back(mk(1, 2'b01, {11'b0, m_drv, !m_dll}, 0));
                    for (int i = 0; i < GAP; i++) q.push_back('0);
                    if (m_dll) begin
                        q.push_back(mk(1, 2'b00, BASE_WORD, 0));
                        for (int i = 0; i < GAP; i++) q.push_back('0);
                    end
                    q.push_back(mk(0, 2'b00, 13'h0, 1));
                    exp_s = q.pop_front();
                    if (m_dll) begin hold = LOCK; last_sr = 0; end
                end
            end else if (q.size() > 0) begin
                exp_s = q.pop_front();
                if (exp_s.done) busy = 0;
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            string ctag;
            logic [3:0] pexp;
            bit rexp;
            if (exp_s.lmr) ctag = (exp_s.ba == 2'b01) ? "R4" : "R5";
            else ctag = (busy && !waiting) ? "R6" : "R7";
            pexp = exp_s.lmr ? 4'b0000 : 4'b0111;
            if (!cmd_cs_n && !cmd_ras_n && !cmd_cas_n && !cmd_we_n) lmr_seen++;
            chk({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == pexp, ctag,
                {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, pexp);
            chk(ba == exp_s.ba, ctag, ba, exp_s.ba);
            chk(addr == exp_s.addr, ctag, addr, exp_s.addr);
            chk(done == exp_s.done, "R10", done, exp_s.done);
            rexp = !busy && hold == 0;
            chk(rd_ok == rexp, last_sr ? "R9" : "R8", rd_ok, rexp);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(bit dll, bit drv);
        @(negedge clk);
        cfg_req = 1; cfg_dll_on = dll; cfg_drive_half = drv;
        @(negedge clk);
        cfg_req = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    task automatic pulse_sr();
        @(negedge clk); sr_exit = 1;
        @(negedge clk); sr_exit = 0;
    endtask

    initial begin
        int n0;
        tick(3);
        // R1: reset state
        chk({cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} == 4'b0111, "R1",
            {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n}, 4'b0111);
        chk(ba == 2'b00 && addr == 13'h0, "R1", {ba, addr}, 0);
        chk(done == 1'b0, "R1", done, 0);
        chk(rd_ok == 1'b1, "R1", rd_ok, 1);
        rst_n = 1;

        // Enable DLL, drive select 1, banks idle
        banks_idle = 1;
        request(1, 1);
        wait_done();
        tick(210);

        // R3: stall while banks busy, DLL disabled (R5: no base load)
        banks_idle = 0;
        n0 = lmr_seen;
        request(0, 0);
        tick(12);
        chk(lmr_seen == n0, "R3", lmr_seen, n0);
        banks_idle = 1;
        wait_done();
        tick(2);
        chk(lmr_seen == n0 + 1, "R5", lmr_seen, n0 + 1);

        // R2: requests during a running sequence are dropped
        n0 = lmr_seen;
        request(1, 0);
        @(negedge clk); cfg_req = 1; cfg_dll_on = 0; cfg_drive_half = 1;
        tick(3);
        cfg_req = 0;
        wait_done();
        tick(10);
        chk(lmr_seen == n0 + 2, "R2", lmr_seen, n0 + 2);
        tick(200);

        // R9: self-refresh exit while idle, then again mid-holdoff
        pulse_sr();
        tick(50);
        pulse_sr();
        tick(205);

        // Self-refresh exit right after an enabling sequence
        request(1, 1);
        wait_done();
        pulse_sr();
        tick(205);

        // Back-to-back: new request in the done cycle (R10)
        request(0, 1);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (done) break;
        end
        cfg_req = 1; cfg_dll_on = 1; cfg_drive_half = 0;
        @(negedge clk); cfg_req = 0;
        wait_done();
        tick(205);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule